// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block lets a host reach a slower, separate register space that is not mapped into the host's own address range. The host loads a target address and, for stores, a data word into two staging registers. It then writes a control register whose low bit picks the direction. That write starts one transaction on an outbound request/acknowledge bus. The host polls a ready flag in the same control register. When a read finishes, it collects the returned word from a read-data register.

The outbound bus holds its request, direction, address and data steady until the far side acknowledges, however many cycles that takes. A 4-bit parity-control value written by the host is driven alongside the request at all times. Board setup normally loads it with all ones. The bridge carries this value but does no checking of its own.

Top module: `ind_reg_bridge`

## Requirements
- R1: After reset the bridge is idle. The ready bit reads 1, req_o is 0, and the address, write-data, read-data and parity registers all read 0.
- R2: Host select codes are 0 address, 1 write data, 2 control/status, 3 read data and 4 parity control. Each readable register returns its stored value, zero-extended to the data width. Codes 5 to 7 read 0, and host writes to codes 3, 5, 6 and 7 change nothing.
- R3: A control write (code 2) while ready with data bit 0 set starts a write transaction. From the next cycle req_o is 1, req_we_o is 1, and req_addr_o and req_wdata_o carry the staged values. The control register then reads bit 1 (ready) = 0 and bit 0 (direction of the last launch) = 1.
- R4: A control write while ready with data bit 0 clear starts a read transaction. From the next cycle req_o is 1 and req_we_o is 0, with the staged address on req_addr_o.
- R5: While req_o is 1 and ack_i is 0, req_o, req_we_o, req_addr_o and req_wdata_o stay unchanged. The cycle after ack_i is seen with req_o high, req_o is 0 and ready reads 1. ack_i while no request is outstanding has no effect.
- R6: Completion of a read loads ack_rdata_i into the read-data register. A write completion, or any other cycle, leaves that register unchanged.
- R7: A control write made while a transaction is outstanding is ignored. This includes the cycle in which the acknowledge arrives.
- R8: The address and write-data registers may be written at any time. They are copied to the outbound bus only at launch, so changing them during a transaction does not alter it.
- R9: req_par_o always equals the parity-control register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_wr_i | input | 1 | Host write strobe for the selected register |
| host_sel_i | input | 3 | Host register select |
| host_wdata_i | input | DATA_W | Host write data |
| host_rdata_o | output | DATA_W | Selected register contents |
| req_o | output | 1 | Outbound transaction pending |
| req_we_o | output | 1 | Outbound direction, 1 = write |
| req_addr_o | output | ADDR_W | Outbound target address |
| req_wdata_o | output | DATA_W | Outbound write data |
| req_par_o | output | PAR_W | Parity-control value carried with the request |
| ack_i | input | 1 | Far side acknowledge |
| ack_rdata_i | input | DATA_W | Far side read data, valid with ack_i |

## Verification
The assertions assume that ack_rdata_i is meaningful in every cycle where ack_i is high with a read pending, and that host_sel_i and host_wr_i carry no unknown values after reset. The bench's slave model returns a fresh random word on every acknowledge, after a delay that is either fixed or random from 0 to 5 cycles. It drops ack_i once req_o falls. In one directed window it drives stray acknowledges while the bridge is idle, to show they are ignored. Host stimulus uses only defined select codes 0 to 5 and changes only away from the clock edge.

// File: rtl/ind_bridge_pkg.sv
package ind_bridge_pkg;
  localparam int SEL_W = 3;
  localparam logic [SEL_W-1:0] SEL_ADDR  = 3'd0;
  localparam logic [SEL_W-1:0] SEL_WDATA = 3'd1;
  localparam logic [SEL_W-1:0] SEL_CTRL  = 3'd2;
  localparam logic [SEL_W-1:0] SEL_RDATA = 3'd3;
  localparam logic [SEL_W-1:0] SEL_PAR   = 3'd4;
  localparam int CTRL_DIR_BIT = 0;
  localparam int CTRL_RDY_BIT = 1;
endpackage

// File: rtl/ibr_host_regs.sv
module ibr_host_regs
  import ind_bridge_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int PAR_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdat_o,
  output logic [PAR_W-1:0]  par_o,
  output logic              ctrl_wr_o,
  output logic              ctrl_dir_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o <= '0;
      wdat_o <= '0;
      par_o  <= '0;
    end else if (wr_i) begin
      if (sel_i == SEL_ADDR)  addr_o <= wdata_i[ADDR_W-1:0];
      if (sel_i == SEL_WDATA) wdat_o <= wdata_i;
      if (sel_i == SEL_PAR)   par_o  <= wdata_i[PAR_W-1:0];
    end
  end

  assign ctrl_wr_o  = wr_i && (sel_i == SEL_CTRL);
  assign ctrl_dir_o = wdata_i[CTRL_DIR_BIT];
endmodule

// File: rtl/ibr_txn_ctrl.sv
module ibr_txn_ctrl #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              launch_i,
  input  logic              dir_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ack_i,
  output logic              req_o,
  output logic              req_we_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic [DATA_W-1:0] req_wdata_o,
  output logic              ready_o,
  output logic              rd_done_o
);
  logic busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q      <= 1'b0;
      req_we_o    <= 1'b0;
      req_addr_o  <= '0;
      req_wdata_o <= '0;
    end else if (!busy_q) begin
      if (launch_i) begin
        busy_q      <= 1'b1;
        req_we_o    <= dir_i;
        req_addr_o  <= addr_i;
        req_wdata_o <= wdata_i;
      end
    end else if (ack_i) begin
      busy_q <= 1'b0;
    end
  end

  assign req_o     = busy_q;
  assign ready_o   = !busy_q;
  assign rd_done_o = busy_q && ack_i && !req_we_o;
endmodule

// File: rtl/ibr_rdata_latch.sv
module ibr_rdata_latch #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (load_i) q_o <= d_i;
  end
endmodule

// File: rtl/ind_reg_bridge.sv
module ind_reg_bridge
  import ind_bridge_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int PAR_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_wr_i,
  input  logic [2:0]        host_sel_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  output logic [DATA_W-1:0] host_rdata_o,
  output logic              req_o,
  output logic              req_we_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic [DATA_W-1:0] req_wdata_o,
  output logic [PAR_W-1:0]  req_par_o,
  input  logic              ack_i,
  input  logic [DATA_W-1:0] ack_rdata_i
);
  logic [ADDR_W-1:0] stg_addr;
  logic [DATA_W-1:0] stg_wdata;
  logic [PAR_W-1:0]  par_q;
  logic              ctrl_wr, ctrl_dir;
  logic              ready, rd_done;
  logic [DATA_W-1:0] rdata_q;
  logic [1:0]        ctrl_word;

  ibr_host_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAR_W(PAR_W)) u_regs (
    .clk_i, .rst_ni,
    .wr_i(host_wr_i), .sel_i(host_sel_i), .wdata_i(host_wdata_i),
    .addr_o(stg_addr), .wdat_o(stg_wdata), .par_o(par_q),
    .ctrl_wr_o(ctrl_wr), .ctrl_dir_o(ctrl_dir)
  );

  ibr_txn_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_txn (
    .clk_i, .rst_ni,
    .launch_i(ctrl_wr), .dir_i(ctrl_dir),
    .addr_i(stg_addr), .wdata_i(stg_wdata), .ack_i,
    .req_o, .req_we_o, .req_addr_o, .req_wdata_o,
    .ready_o(ready), .rd_done_o(rd_done)
  );

  ibr_rdata_latch #(.DATA_W(DATA_W)) u_rdl (
    .clk_i, .rst_ni, .load_i(rd_done), .d_i(ack_rdata_i), .q_o(rdata_q)
  );

  assign req_par_o = par_q;

  always_comb begin
    ctrl_word = '0;
    ctrl_word[CTRL_RDY_BIT] = ready;
    ctrl_word[CTRL_DIR_BIT] = req_we_o;
  end

  always_comb begin
    case (host_sel_i)
      SEL_ADDR:  host_rdata_o = DATA_W'(stg_addr);
      SEL_WDATA: host_rdata_o = stg_wdata;
      SEL_CTRL:  host_rdata_o = DATA_W'(ctrl_word);
      SEL_RDATA: host_rdata_o = rdata_q;
      SEL_PAR:   host_rdata_o = DATA_W'(par_q);
      default:   host_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/ibr_checker.sv
module ibr_checker
  import ind_bridge_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              host_wr_i,
  input logic [2:0]        host_sel_i,
  input logic              ack_i,
  input logic [DATA_W-1:0] ack_rdata_i,
  input logic              req_o,
  input logic              req_we_o,
  input logic [ADDR_W-1:0] req_addr_o,
  input logic [DATA_W-1:0] req_wdata_o,
  input logic              ready,
  input logic [DATA_W-1:0] rdata_q
);
  a_r3_launch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_wr_i && host_sel_i == SEL_CTRL && ready |=> req_o && !ready);

  a_r3_no_self_launch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_o && !(host_wr_i && host_sel_i == SEL_CTRL) |=> !req_o);

  a_r5_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && !ack_i |=> req_o && $stable(req_we_o) && $stable(req_addr_o)
                        && $stable(req_wdata_o));

  a_r5_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && ack_i |=> !req_o && ready);

  a_r6_rdata_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && ack_i && !req_we_o |=> rdata_q == $past(ack_rdata_i));

  a_r6_rdata_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_o && ack_i && !req_we_o) |=> $stable(rdata_q));
endmodule

bind ind_reg_bridge ibr_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .host_wr_i(host_wr_i), .host_sel_i(host_sel_i),
  .ack_i(ack_i), .ack_rdata_i(ack_rdata_i), .req_o(req_o), .req_we_o(req_we_o),
  .req_addr_o(req_addr_o), .req_wdata_o(req_wdata_o), .ready(ready),
  .rdata_q(rdata_q)
);

// File: tb/ind_reg_bridge_tb_top.sv
module ind_reg_bridge_tb_top;
  localparam int CLK_P  = 10;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int PAR_W  = 4;

  logic clk = 0, rst_n = 0;
  logic              host_wr_i = 0;
  logic [2:0]        host_sel_i = 0;
  logic [DATA_W-1:0] host_wdata_i = 0;
  logic [DATA_W-1:0] host_rdata_o;
  logic              req_o, req_we_o;
  logic [ADDR_W-1:0] req_addr_o;
  logic [DATA_W-1:0] req_wdata_o;
  logic [PAR_W-1:0]  req_par_o;
  logic              ack_i = 0;
  logic [DATA_W-1:0] ack_rdata_i = 0;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit mon_en = 0;

  // slave model controls
  int s_fix = -1;
  int s_cnt = 0;
  bit s_seen = 0, s_stray = 0;
  logic [DATA_W-1:0] s_last = 0;

  // reference model state
  logic [ADDR_W-1:0] m_addr;
  logic [DATA_W-1:0] m_wdata, m_rdata, m_req_wdata;
  logic [ADDR_W-1:0] m_req_addr;
  logic [PAR_W-1:0]  m_par;
  bit m_busy, m_we;

  always #(CLK_P/2) clk = ~clk;

  ind_reg_bridge #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAR_W(PAR_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .host_wr_i, .host_sel_i, .host_wdata_i,
    .host_rdata_o, .req_o, .req_we_o, .req_addr_o, .req_wdata_o, .req_par_o,
    .ack_i, .ack_rdata_i
  );

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic report();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  // reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_addr = 0; m_wdata = 0; m_rdata = 0; m_par = 0;
      m_req_addr = 0; m_req_wdata = 0; m_busy = 0; m_we = 0;
    end else begin
      bit was_busy;
      was_busy = m_busy;
      if (was_busy && ack_i) begin
        m_busy = 0;
        if (!m_we) m_rdata = ack_rdata_i;
      end
      if (host_wr_i && host_sel_i == 3'd2 && !was_busy) begin
        m_busy = 1; m_we = host_wdata_i[0];
        m_req_addr = m_addr; m_req_wdata = m_wdata;
      end
      if (host_wr_i) begin
        if (host_sel_i == 3'd0) m_addr = host_wdata_i[ADDR_W-1:0];
        if (host_sel_i == 3'd1) m_wdata = host_wdata_i;
        if (host_sel_i == 3'd4) m_par = host_wdata_i[PAR_W-1:0];
      end
    end
  end

  // per-cycle compare, then slave response
  always @(negedge clk) begin
    #1;
    if (mon_en) begin
      logic [DATA_W-1:0] exp;
      string tag;
      case (host_sel_i)
        3'd0: begin exp = DATA_W'(m_addr); tag = "R2 addr"; end
        3'd1: begin exp = m_wdata; tag = "R2 wdata"; end
        3'd2: begin exp = DATA_W'({!m_busy, m_we}); tag = "R3 ctrl"; end
        3'd3: begin exp = m_rdata; tag = "R6 rdata"; end
        3'd4: begin exp = DATA_W'(m_par); tag = "R2 par"; end
        default: begin exp = 0; tag = "R2 unused"; end
      endcase
      chk(tag, host_rdata_o, exp);
      chk("R5 req", req_o, m_busy);
      chk("R9 par out", req_par_o, m_par);
      if (m_busy) begin
        chk("R4 dir", req_we_o, m_we);
        chk("R8 addr out", req_addr_o, m_req_addr);
        chk("R8 wdata out", req_wdata_o, m_req_wdata);
      end
    end
    ack_rdata_i = $urandom;
    if (req_o) begin
      if (!s_seen) begin
        s_seen = 1;
        s_cnt = (s_fix >= 0) ? s_fix : $urandom_range(0, 5);
      end
      if (s_cnt == 0) begin ack_i = 1; s_last = ack_rdata_i; end
      else begin ack_i = 0; s_cnt--; end
    end else begin
      s_seen = 0;
      ack_i = s_stray;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  task automatic hwr(input logic [2:0] s, input logic [DATA_W-1:0] d);
    @(negedge clk);
    host_wr_i = 1; host_sel_i = s; host_wdata_i = d;
    @(posedge clk); #1 host_wr_i = 0;
  endtask

  task automatic hrd(input logic [2:0] s, output logic [DATA_W-1:0] v);
    @(negedge clk);
    host_wr_i = 0; host_sel_i = s;
    #2 v = host_rdata_o;
  endtask

  task automatic wait_ready(input string tag);
    logic [DATA_W-1:0] v;
    bit ok = 0;
    for (int i = 0; i < 100; i++) begin
      hrd(3'd2, v);
      if (v[1]) begin ok = 1; break; end
    end
    chk(tag, ok, 1);
  endtask

  initial begin
    logic [DATA_W-1:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    hrd(3'd0, v); chk("R1 addr", v, 0);
    hrd(3'd1, v); chk("R1 wdata", v, 0);
    hrd(3'd2, v); chk("R1 ctrl ready", v, 32'h2);
    hrd(3'd3, v); chk("R1 rdata", v, 0);
    hrd(3'd4, v); chk("R1 par", v, 0);
    chk("R1 req", req_o, 0);
    mon_en = 1;

    // R2 register map, R9 parity
    hwr(3'd0, 32'h0000_1234);
    hwr(3'd1, 32'hCAFE_F00D);
    hwr(3'd4, 32'hFFFF_FFFF);
    hrd(3'd0, v); chk("R2 addr", v, 32'h1234);
    hrd(3'd1, v); chk("R2 wdata", v, 32'hCAFEF00D);
    hrd(3'd4, v); chk("R2 par", v, 32'hF);
    chk("R9 par out", req_par_o, 4'hF);
    hwr(3'd3, 32'h5A5A_5A5A);
    hrd(3'd3, v); chk("R2 rdata read-only", v, 0);
    hrd(3'd5, v); chk("R2 unused", v, 0);

    // R3 write launch, R7 ignored ctrl, R8 staging during busy
    s_fix = 6;
    hwr(3'd2, 32'h1);
    hrd(3'd2, v); chk("R3 ctrl busy", v, 32'h1);
    chk("R3 req", req_o, 1);
    chk("R3 we", req_we_o, 1);
    chk("R3 addr", req_addr_o, 16'h1234);
    chk("R3 wdata", req_wdata_o, 32'hCAFEF00D);
    hwr(3'd2, 32'h0);
    hwr(3'd0, 32'h0000_5555);
    hwr(3'd1, 32'h1111_2222);
    chk("R7 we kept", req_we_o, 1);
    chk("R8 addr kept", req_addr_o, 16'h1234);
    chk("R8 wdata kept", req_wdata_o, 32'hCAFEF00D);
    wait_ready("R5 write done");
    hrd(3'd3, v); chk("R6 rdata after write", v, 0);

    // R4 read launch, R6 capture
    s_fix = 0;
    hwr(3'd2, 32'h0);
    @(negedge clk); #2;
    chk("R4 req", req_o, 1);
    chk("R4 we", req_we_o, 0);
    chk("R4 addr", req_addr_o, 16'h5555);
    wait_ready("R5 read done");
    hrd(3'd3, v); chk("R6 rdata", v, s_last);

    // R5 stray acknowledge ignored
    s_stray = 1;
    repeat (4) @(negedge clk);
    s_stray = 0;
    hrd(3'd2, v); chk("R5 stray ctrl", v, 32'h2);
    hrd(3'd3, v); chk("R5 stray rdata", v, s_last);
    chk("R5 stray req", req_o, 0);

    // R7 ctrl written every cycle while busy, including ack cycle
    s_fix = 2;
    @(negedge clk);
    host_wr_i = 1; host_sel_i = 3'd2; host_wdata_i = 32'h1;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk); #2;
      if (host_rdata_o[1]) break;
    end
    host_wr_i = 0;
    @(negedge clk); #2;
    chk("R7 no relaunch", req_o, 0);
    hrd(3'd2, v); chk("R7 ctrl", v, 32'h3);

    // R9 parity change
    hwr(3'd4, 32'h0000_003A);
    chk("R9 par out", req_par_o, 4'hA);

    // random traffic against the model
    s_fix = -1;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      host_wr_i = ($urandom_range(0, 3) == 0);
      host_sel_i = 3'($urandom_range(0, 5));
      host_wdata_i = $urandom;
    end
    @(negedge clk); host_wr_i = 0;
    repeat (10) @(negedge clk);
    report();
  end
endmodule